// File: doc/BRIEF.md
# Floating-Point Issue Reservation Tracker

This block sits beside the floating-point issue stage and answers one question each cycle: may the offered floating-point operation start now? It tracks three shared resources: the add pipe, the multiply pipe and a non-pipelined divide/square-root unit. Each resource has a down-counter of the cycles it stays reserved after the issue cycle. An operation is accepted only when every resource it needs is free. On acceptance the block loads the counter with the operation's hold span. It also reports the result latency, so the issue logic can schedule dependants.

A refused request reserves nothing, and the requester offers it again on a later cycle. Each accepted divide starts its own result timer. The block raises a one-cycle done pulse when a divide's latency runs out. A second divide can start before the first one's result is due, so the timers are independent of the unit's hold counter. Arithmetic datapaths are outside this block.

Top module: `fpres_tracker`

## Requirements
- R1: After reset all busy outputs, `accept`, `div_done` and `result_latency` are low while no request is offered.
- R2: `accept` is high only in a cycle where `req_valid` is high, the code is known, and no resource the operation needs is reserved. A refused request changes no reservation.
- R3: Codes 0 (add/compare/convert/copy, latency 4) and 1 (constant load, latency 3) use the add pipe in the issue cycle only, so such operations can be accepted on consecutive cycles.
- R4: Codes 2 (single multiply, latency 4) and 3 (single multiply-accumulate, latency 8) use the multiply pipe in the issue cycle only.
- R5: Codes 4 (double multiply, latency 7) and 5 (double multiply-accumulate, latency 11) hold the multiply pipe for 4 consecutive cycles. Any multiply-pipe operation (codes 2 to 7) offered in the 3 following cycles is refused.
- R6: Code 6 (double fused multiply-add, latency 8) holds the multiply pipe for 5 cycles.
- R7: Code 7 (vector multiply, latency 4) holds the multiply pipe for 2 cycles.
- R8: Add-pipe and divide operations are accepted while the multiply pipe is held.
- R9: Code 8 (single divide, latency 16) holds the divide unit for 14 cycles. Code 9 (double divide, latency 31) holds it for 29 cycles. A divide offered while the unit is held is refused.
- R10: `div_done` pulses for one cycle exactly latency cycles after each divide's acceptance cycle, including when a later divide is already in flight.
- R11: Codes 10 to 15 are never accepted, give `result_latency` 0 and reserve nothing.
- R12: Each busy output is high in the issue cycle of an operation using that resource and in every held cycle after it, and low otherwise. `result_latency` equals the accepted operation's latency and is 0 when nothing is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | An operation is offered this cycle |
| req_op | input | 4 | Operation class code (see requirements) |
| accept | output | 1 | The offered operation starts this cycle |
| add_busy | output | 1 | Add pipe occupied this cycle |
| mul_busy | output | 1 | Multiply pipe occupied this cycle |
| div_busy | output | 1 | Divide unit occupied this cycle |
| div_done | output | 1 | A divide result's latency expires this cycle |
| result_latency | output | 5 | Latency of the accepted operation, else 0 |

## Verification
The case hardest to reach from the ports is two divides in flight at once: the earlier result is still pending while the unit already works on the next one. The stimulus starts a single divide and then offers a double divide on every cycle. The double divide is refused until the unit frees, 14 cycles later, and its acceptance then overlaps the first divide's outstanding done pulse. The reverse order, a single divide waiting behind a double one, is covered the same way. A behavioural model in the bench, kept as remaining-cycle integers and a queue of due cycles, is compared with the outputs on every clock.

// File: rtl/fpres_pkg.sv
package fpres_pkg;
  localparam int OP_W  = 4;
  localparam int CNT_W = 5;

  typedef enum logic [OP_W-1:0] {
    OP_FADD   = 4'd0,
    OP_FCONST = 4'd1,
    OP_MULS   = 4'd2,
    OP_MACS   = 4'd3,
    OP_MULD   = 4'd4,
    OP_MACD   = 4'd5,
    OP_FMAD   = 4'd6,
    OP_VMUL   = 4'd7,
    OP_DIVS   = 4'd8,
    OP_DIVD   = 4'd9
  } fp_op_e;

  function automatic logic op_known(input fp_op_e op);
    return op <= OP_DIVD;
  endfunction

  function automatic logic op_uses_add(input fp_op_e op);
    return (op == OP_FADD) || (op == OP_FCONST);
  endfunction

  function automatic logic op_uses_mul(input fp_op_e op);
    return (op >= OP_MULS) && (op <= OP_VMUL);
  endfunction

  function automatic logic op_uses_div(input fp_op_e op);
    return (op == OP_DIVS) || (op == OP_DIVD);
  endfunction

  // Cycles the resource stays occupied, counting the issue cycle.
  function automatic logic [CNT_W-1:0] op_hold(input fp_op_e op);
    case (op)
      OP_MULD, OP_MACD: return 5'd4;
      OP_FMAD:          return 5'd5;
      OP_VMUL:          return 5'd2;
      OP_DIVS:          return 5'd14;
      OP_DIVD:          return 5'd29;
      default:          return 5'd1;
    endcase
  endfunction

  function automatic logic [CNT_W-1:0] op_latency(input fp_op_e op);
    case (op)
      OP_FADD, OP_MULS, OP_VMUL: return 5'd4;
      OP_FCONST:                 return 5'd3;
      OP_MACS, OP_FMAD:          return 5'd8;
      OP_MULD:                   return 5'd7;
      OP_MACD:                   return 5'd11;
      OP_DIVS:                   return 5'd16;
      OP_DIVD:                   return 5'd31;
      default:                   return 5'd0;
    endcase
  endfunction
endpackage

// File: rtl/fpres_hold_counter.sv
module fpres_hold_counter #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] cnt,
  output logic         held
);
  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign held = (cnt != '0);
endmodule

// File: rtl/fpres_done_timers.sv
module fpres_done_timers #(
  parameter int W     = 5,
  parameter int SLOTS = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] start_lat,
  output logic         done
);
  logic [W-1:0]     timer [SLOTS];
  logic [SLOTS-1:0] free;
  logic [SLOTS-1:0] pick;
  logic [SLOTS-1:0] hit;

  always_comb begin
    pick = '0;
    for (int i = 0; i < SLOTS; i++)
      if (free[i] && pick == '0) pick[i] = 1'b1;
  end

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    assign free[g] = (timer[g] == '0);
    assign hit[g]  = (timer[g] == W'(1));
    always_ff @(posedge clk) begin
      if (!rst_n)                 timer[g] <= '0;
      else if (start && pick[g])  timer[g] <= start_lat;
      else if (!free[g])          timer[g] <= timer[g] - 1'b1;
    end
  end

  assign done = |hit;
endmodule

// File: rtl/fpres_tracker.sv
module fpres_tracker
  import fpres_pkg::*;
#(
  parameter int DONE_SLOTS = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [OP_W-1:0]  req_op,
  output logic             accept,
  output logic             add_busy,
  output logic             mul_busy,
  output logic             div_busy,
  output logic             div_done,
  output logic [CNT_W-1:0] result_latency
);
  fp_op_e           op;
  logic             known, need_add, need_mul, need_div;
  logic             add_held, mul_held, div_held, conflict;
  logic [CNT_W-1:0] add_cnt, mul_cnt, div_cnt;
  logic [CNT_W-1:0] hold_rest;
  logic             load_add, load_mul, load_div;

  assign op       = fp_op_e'(req_op);
  assign known    = op_known(op);
  assign need_add = op_uses_add(op);
  assign need_mul = op_uses_mul(op);
  assign need_div = op_uses_div(op);

  assign conflict = (need_add && add_held) || (need_mul && mul_held) ||
                    (need_div && div_held);
  assign accept   = req_valid && known && !conflict;

  assign hold_rest = op_hold(op) - 1'b1;
  assign load_add  = accept && need_add;
  assign load_mul  = accept && need_mul;
  assign load_div  = accept && need_div;

  fpres_hold_counter #(.W(CNT_W)) u_add (
    .clk(clk), .rst_n(rst_n), .load(load_add), .load_val(hold_rest),
    .cnt(add_cnt), .held(add_held));

  fpres_hold_counter #(.W(CNT_W)) u_mul (
    .clk(clk), .rst_n(rst_n), .load(load_mul), .load_val(hold_rest),
    .cnt(mul_cnt), .held(mul_held));

  fpres_hold_counter #(.W(CNT_W)) u_div (
    .clk(clk), .rst_n(rst_n), .load(load_div), .load_val(hold_rest),
    .cnt(div_cnt), .held(div_held));

  fpres_done_timers #(.W(CNT_W), .SLOTS(DONE_SLOTS)) u_done (
    .clk(clk), .rst_n(rst_n), .start(load_div),
    .start_lat(op_latency(op)), .done(div_done));

  assign add_busy       = add_held || load_add;
  assign mul_busy       = mul_held || load_mul;
  assign div_busy       = div_held || load_div;
  assign result_latency = accept ? op_latency(op) : '0;
endmodule

// File: rtl/fpres_checker.sv
module fpres_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic [3:0] req_op,
  input logic       accept,
  input logic       add_busy,
  input logic       mul_busy,
  input logic       div_busy,
  input logic       div_done,
  input logic [4:0] result_latency,
  input logic [4:0] add_cnt,
  input logic [4:0] mul_cnt,
  input logic [4:0] div_cnt
);
  a_r2_accept_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> req_valid);

  a_r3_add_busy_on_issue: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_op <= 4'd1) |-> add_busy);

  a_r3_add_never_held: assert property (@(posedge clk) disable iff (!rst_n)
    add_cnt == 5'd0);

  a_r5_mul_refused_while_held: assert property (@(posedge clk) disable iff (!rst_n)
    (mul_cnt != 5'd0 && req_valid && req_op >= 4'd2 && req_op <= 4'd7) |-> !accept);

  a_r5_mul_counts_down: assert property (@(posedge clk) disable iff (!rst_n)
    (mul_cnt != 5'd0) |=> (mul_cnt == 5'($past(mul_cnt) - 5'd1)));

  a_r9_div_refused_while_held: assert property (@(posedge clk) disable iff (!rst_n)
    (div_cnt != 5'd0 && req_valid && (req_op == 4'd8 || req_op == 4'd9)) |-> !accept);

  a_r9_div_single_span: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_op == 4'd8) |=> (div_cnt == 5'd13));

  a_r10_done_is_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    div_done |=> !div_done);

  a_r11_unknown_refused: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op > 4'd9) |-> (!accept && result_latency == 5'd0));

  a_r12_held_means_busy: assert property (@(posedge clk) disable iff (!rst_n)
    ((mul_cnt != 5'd0) |-> mul_busy) and ((div_cnt != 5'd0) |-> div_busy));
endmodule

bind fpres_tracker fpres_checker i_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
  .accept(accept), .add_busy(add_busy), .mul_busy(mul_busy),
  .div_busy(div_busy), .div_done(div_done), .result_latency(result_latency),
  .add_cnt(add_cnt), .mul_cnt(mul_cnt), .div_cnt(div_cnt));

// File: tb/test_fpres_tracker.sv
module test_fpres_tracker;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic [3:0] req_op = 4'd0;
  logic       accept, add_busy, mul_busy, div_busy, div_done;
  logic [4:0] result_latency;

  int checks = 0;
  int errors = 0;

  // Model tables indexed by code: 0 none, 1 add, 2 mul, 3 div.
  int res_of  [10] = '{1, 1, 2, 2, 2, 2, 2, 2, 3, 3};
  int span_of [10] = '{1, 1, 1, 1, 4, 4, 5, 2, 14, 29};
  int lat_of  [10] = '{4, 3, 4, 8, 7, 11, 8, 4, 16, 31};

  int rem [4];
  int cyc = 0;
  int due_q [$];
  bit last_acc;

  always #10 clk = ~clk;

  fpres_tracker i_fpres_tracker (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .accept(accept), .add_busy(add_busy), .mul_busy(mul_busy),
    .div_busy(div_busy), .div_done(div_done), .result_latency(result_latency));

  task automatic step(input bit v, input int code, input string tag);
    int r;
    bit e_acc, e_done;
    bit [3:0] e_busy;
    int e_lat;
    int keep [$];
    req_valid = v;
    req_op = code[3:0];
    #2;
    r = (code < 10) ? res_of[code] : 0;
    e_acc = v && (r != 0) && (rem[r] == 0);
    e_lat = e_acc ? lat_of[code] : 0;
    for (int k = 1; k < 4; k++) e_busy[k] = (rem[k] > 0) || (e_acc && r == k);
    e_busy[0] = 1'b0;
    e_done = 1'b0;
    foreach (due_q[i]) if (due_q[i] == cyc) e_done = 1'b1;
    checks++;
    if (accept !== e_acc || add_busy !== e_busy[1] || mul_busy !== e_busy[2] ||
        div_busy !== e_busy[3] || div_done !== e_done || result_latency !== 5'(e_lat)) begin
      errors++;
      $display("FAIL %s cyc %0d op %0d: acc/add/mul/div/done/lat got %b%b%b%b%b/%0d expected %b%b%b%b%b/%0d",
               tag, cyc, code, accept, add_busy, mul_busy, div_busy, div_done,
               result_latency, e_acc, e_busy[1], e_busy[2], e_busy[3], e_done, e_lat);
    end
    for (int k = 1; k < 4; k++) if (rem[k] > 0) rem[k]--;
    if (e_acc) begin
      rem[r] = span_of[code] - 1;
      if (r == 3) due_q.push_back(cyc + lat_of[code]);
    end
    foreach (due_q[i]) if (due_q[i] > cyc) keep.push_back(due_q[i]);
    due_q = keep;
    last_acc = e_acc;
    cyc++;
    @(negedge clk);
  endtask

  task automatic issue(input int code, input string tag);
    for (int n = 0; n < 40; n++) begin
      step(1'b1, code, tag);
      if (last_acc) break;
    end
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(1'b0, 0, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int k = 0; k < 4; k++) rem[k] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    idle(2, "R1");
    // R3 add pipe back to back, constant load
    step(1, 0, "R3"); step(1, 0, "R3"); step(1, 1, "R3"); idle(1, "R12");
    // R4 single-precision multiply ops
    step(1, 2, "R4"); step(1, 3, "R4"); step(1, 2, "R4"); idle(1, "R12");
    // R5 double multiply blocks multiplies, R8 lets others through
    step(1, 4, "R5"); step(1, 2, "R5"); step(1, 0, "R8"); step(1, 3, "R5");
    issue(2, "R5"); step(1, 5, "R5"); step(1, 7, "R5"); step(1, 8, "R8");
    step(1, 1, "R8"); issue(6, "R5");
    // R6 fused double MAC
    issue(3, "R6"); idle(1, "R12");
    // R7 vector multiply
    step(1, 7, "R7"); step(1, 2, "R7"); issue(2, "R7");
    idle(20, "R10");
    // R9 / R10 overlapping divides
    step(1, 8, "R9"); issue(9, "R9"); issue(8, "R10");
    idle(40, "R10");
    // R11 unknown codes, idle and while multiply held
    for (int c = 10; c < 16; c++) step(1, c, "R11");
    step(1, 4, "R11"); step(1, 12, "R11"); step(1, 15, "R11"); step(1, 2, "R11");
    issue(2, "R11"); step(1, 9, "R2"); step(1, 13, "R11"); issue(8, "R2");
    idle(40, "R12");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule